// File: doc/BRIEF.md
# Home-Node Coherence Directory Controller

This block sits at the home node of a distributed shared-memory system and keeps, for every memory block it owns, a three-state coherence entry (Uncached, Shared, Exclusive) together with a vector that has one bit per node and marks the nodes that hold a copy. Remote nodes send it read-miss, write-miss and write-back requests. The controller answers with data replies and, when other caches must give up or hand over a copy, it sends invalidate, fetch or fetch-and-invalidate interventions. It then collects the acknowledgments or owner data that come back before it completes the request.

A small memory array inside the block acts as the backing store. One transaction is in flight at a time. While a request waits for remote nodes, new requests are held off by keeping the request channel's ready low. Interventions to several nodes leave on one channel, one per cycle, lowest node id first. Each acknowledgment or data response counts against the number of responses still owed. The directory entry is written once, when that count reaches zero and every intervention has been sent. The reply follows after that write.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every directory entry is Uncached with an empty sharer vector, every backing-store word is zero, the request channel is ready, and no intervention or reply is offered.
- R2: A read miss (request type 0) to an Uncached or Shared block, or from the block's own Exclusive owner, returns the stored word to the requester with no intervention. The requester's bit is added to the sharer vector and the entry becomes Shared.
- R3: A write miss (request type 1) to an Uncached block returns the stored word with no intervention. The sharer vector becomes only the requester and the entry becomes Exclusive.
- R4: A write miss to a Shared block sends an invalidate (intervention type 0) to every sharer except the requester. The reply carries the stored word and is offered only after one acknowledgment (response type 0) per invalidate has been accepted. The entry then becomes Exclusive with only the requester.
- R5: A read miss to a block held Exclusive by another node sends a fetch (intervention type 1) to the owner. The data response (response type 1) from that owner is written to the backing store and forwarded in the reply. The entry becomes Shared, holding both the old owner and the requester.
- R6: A write miss to a block held Exclusive by another node sends a fetch-and-invalidate (intervention type 2) to the owner. The owner's returned data is forwarded in the reply, and the entry stays Exclusive with only the requester.
- R7: A write-back (request type 2) from the Exclusive owner stores its data, and the entry becomes Uncached with an empty vector, with no reply. A write-back from any other node, or to a block not held Exclusive, has no effect on the directory or the store.
- R8: Once a request is accepted, the request channel stays not-ready until the reply is taken (or, with no reply, until the directory is updated). It is ready again in the cycle after.
- R9: Interventions for one request go out one per cycle at most, in strictly ascending node-id order, and never to the requester.
- R10: A reply that is not taken stays offered with the same node, block and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_type | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_node | input | NODE_W | Requesting node id |
| req_blk | input | BLK_W | Block index |
| req_data | input | DATA_W | Write-back data |
| ivn_valid | output | 1 | Intervention offered |
| ivn_ready | input | 1 | Intervention taken |
| ivn_type | output | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate |
| ivn_node | output | NODE_W | Target node |
| ivn_blk | output | BLK_W | Block index |
| rsp_valid | input | 1 | Remote response offered |
| rsp_ready | output | 1 | Response accepted |
| rsp_type | input | 1 | 0 acknowledgment, 1 owner data |
| rsp_node | input | NODE_W | Responding node |
| rsp_data | input | DATA_W | Owner data |
| rep_valid | output | 1 | Data reply offered |
| rep_ready | input | 1 | Reply taken |
| rep_node | output | NODE_W | Destination node |
| rep_blk | output | BLK_W | Block index |
| rep_data | output | DATA_W | Block data |

## Verification
Two activities of this block can land in the same clock edge: issuing the next invalidate, and accepting the acknowledgment for an earlier one. The bench provokes this on write misses to widely shared blocks by holding the intervention channel ready. Its responder then answers each invalidate on the very next cycle, so acknowledgments arrive while later invalidates are still leaving. The bench judges the result by the exact ascending list of invalidate targets, and by confirming that no reply is offered while an invalidate is unsent or an acknowledgment is unconsumed. Later accesses to the block must also show the directory state a reference model predicts.

// File: rtl/hdir_pkg.sv
package hdir_pkg;
  timeunit 1ns; timeprecision 1ps;

  typedef enum logic [1:0] {DS_UNC = 2'd0, DS_SHR = 2'd1, DS_EXC = 2'd2} dstate_e;
  typedef enum logic [1:0] {RQ_READ = 2'd0, RQ_WRITE = 2'd1, RQ_WBACK = 2'd2} rqtype_e;
  typedef enum logic [1:0] {IV_INV = 2'd0, IV_FETCH = 2'd1, IV_FETCHINV = 2'd2} ivtype_e;
  typedef enum logic [1:0] {E_IDLE = 2'd0, E_WAIT = 2'd1, E_REPLY = 2'd2} engst_e;

  localparam logic RS_ACK  = 1'b0;
  localparam logic RS_DATA = 1'b1;

  // number of set bits in a vector of up to 64 nodes
  function automatic int unsigned popcnt64(input logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) n = n + {31'd0, v[i]};
    return n;
  endfunction
endpackage

// File: rtl/hdir_table.sv
module hdir_table
  import hdir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 16,
  parameter int BLK_W  = $clog2(BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] rd_blk,
  output logic [1:0]       rd_st,
  output logic [NODES-1:0] rd_sh,
  input  logic             wr_en,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic [1:0]       wr_st,
  input  logic [NODES-1:0] wr_sh
);
  timeunit 1ns; timeprecision 1ps;

  logic [1:0]       st_q [BLOCKS];
  logic [NODES-1:0] sh_q [BLOCKS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BLOCKS; i++) begin
        st_q[i] <= DS_UNC;
        sh_q[i] <= '0;
      end
    end else if (wr_en) begin
      st_q[wr_blk] <= wr_st;
      sh_q[wr_blk] <= wr_sh;
    end
  end

  assign rd_st = st_q[rd_blk];
  assign rd_sh = sh_q[rd_blk];

  // R6: an exclusive entry names exactly one owner
  a_r6_excl_one: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_st == DS_EXC |-> $countones(wr_sh) == 1);
  // R7: an uncached entry has no sharers
  a_r7_unc_empty: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_st == DS_UNC |-> wr_sh == '0);
  // R2: a shared entry has at least one sharer
  a_r2_shr_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_st == DS_SHR |-> wr_sh != '0);
endmodule

// File: rtl/hdir_store.sv
module hdir_store #(
  parameter int BLOCKS = 16,
  parameter int DATA_W = 32,
  parameter int BLK_W  = $clog2(BLOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLK_W-1:0]  rd_blk,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [BLK_W-1:0]  wr_blk,
  input  logic [DATA_W-1:0] wr_data
);
  timeunit 1ns; timeprecision 1ps;

  logic [DATA_W-1:0] mem_q [BLOCKS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BLOCKS; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_blk] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_blk];
endmodule

// File: rtl/hdir_decide.sv
module hdir_decide
  import hdir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int NODE_W = $clog2(NODES),
  parameter int CNT_W  = $clog2(NODES + 1)
) (
  input  logic [1:0]        st,
  input  logic [NODES-1:0]  sh,
  input  logic [1:0]        rq_type,
  input  logic [NODE_W-1:0] rq_node,
  output logic [NODES-1:0]  iv_mask,
  output logic [1:0]        iv_kind,
  output logic [CNT_W-1:0]  pend,
  output logic [1:0]        new_st,
  output logic [NODES-1:0]  new_sh,
  output logic              wr_mem,
  output logic              use_fetch,
  output logic              do_reply
);
  timeunit 1ns; timeprecision 1ps;

  logic [NODES-1:0] own;
  logic [NODES-1:0] others;

  always_comb begin
    own          = '0;
    own[rq_node] = 1'b1;
    others       = sh & ~own;
    iv_mask   = '0;
    iv_kind   = IV_INV;
    pend      = '0;
    new_st    = st;
    new_sh    = sh;
    wr_mem    = 1'b0;
    use_fetch = 1'b0;
    do_reply  = 1'b0;
    case (rqtype_e'(rq_type))
      RQ_READ: begin
        new_st   = DS_SHR;
        new_sh   = sh | own;
        do_reply = 1'b1;
        if (st == DS_EXC && others != '0) begin
          iv_mask   = others;
          iv_kind   = IV_FETCH;
          pend      = CNT_W'(1);
          use_fetch = 1'b1;
          wr_mem    = 1'b1;
        end
      end
      RQ_WRITE: begin
        new_st   = DS_EXC;
        new_sh   = own;
        do_reply = 1'b1;
        if (st == DS_EXC && others != '0) begin
          iv_mask   = others;
          iv_kind   = IV_FETCHINV;
          pend      = CNT_W'(1);
          use_fetch = 1'b1;
        end else if (st == DS_SHR) begin
          iv_mask = others;
          iv_kind = IV_INV;
          pend    = CNT_W'(popcnt64(64'(others)));
        end
      end
      RQ_WBACK: begin
        if (st == DS_EXC && sh == own) begin
          new_st = DS_UNC;
          new_sh = '0;
          wr_mem = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hdir_pick.sv
module hdir_pick #(
  parameter int NODES  = 4,
  parameter int NODE_W = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NODES-1:0]  mask,
  output logic              any,
  output logic [NODE_W-1:0] idx
);
  timeunit 1ns; timeprecision 1ps;

  logic [NODES-1:0] below;
  logic [NODES-1:0] grant;

  assign below[0] = 1'b0;
  for (genvar g = 1; g < NODES; g++) begin : g_chain
    assign below[g] = below[g-1] | mask[g-1];
  end
  assign grant = mask & ~below;
  assign any   = |mask;

  always_comb begin
    idx = '0;
    for (int i = 0; i < NODES; i++)
      if (grant[i]) idx = NODE_W'(i);
  end

  // R9: at most one target granted per cycle
  a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any == (grant != '0)));
endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
  import hdir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 16,
  parameter int DATA_W = 32,
  parameter int NODE_W = $clog2(NODES),
  parameter int BLK_W  = $clog2(BLOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_type,
  input  logic [NODE_W-1:0] req_node,
  input  logic [BLK_W-1:0]  req_blk,
  input  logic [DATA_W-1:0] req_data,
  output logic              ivn_valid,
  input  logic              ivn_ready,
  output logic [1:0]        ivn_type,
  output logic [NODE_W-1:0] ivn_node,
  output logic [BLK_W-1:0]  ivn_blk,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic              rsp_type,
  input  logic [NODE_W-1:0] rsp_node,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              rep_valid,
  input  logic              rep_ready,
  output logic [NODE_W-1:0] rep_node,
  output logic [BLK_W-1:0]  rep_blk,
  output logic [DATA_W-1:0] rep_data
);
  timeunit 1ns; timeprecision 1ps;

  localparam int CNT_W = $clog2(NODES + 1);

  engst_e            eng_q;
  logic [NODE_W-1:0] node_q;
  logic [BLK_W-1:0]  blk_q;
  logic [DATA_W-1:0] wbdata_q;
  logic [DATA_W-1:0] data_q;
  logic [NODES-1:0]  mask_q;
  logic [1:0]        kind_q;
  logic [CNT_W-1:0]  pend_q;
  logic [1:0]        nst_q;
  logic [NODES-1:0]  nsh_q;
  logic              wrmem_q;
  logic              fetch_q;
  logic              reply_q;
  logic [NODE_W-1:0] fnode_q;

  // table and store read ports (addressed by the incoming request)
  logic [1:0]        tb_st;
  logic [NODES-1:0]  tb_sh;
  logic [DATA_W-1:0] st_rd;

  // decision for the incoming request
  logic [NODES-1:0]  d_mask;
  logic [1:0]        d_kind;
  logic [CNT_W-1:0]  d_pend;
  logic [1:0]        d_nst;
  logic [NODES-1:0]  d_nsh;
  logic              d_wrmem, d_fetch, d_reply;

  // named events
  logic              accept, ivn_fire, rsp_fire, commit, rep_fire;
  logic              pick_any;
  logic [NODE_W-1:0] pick_idx;
  logic [NODES-1:0]  clr_bit;

  hdir_table #(.NODES(NODES), .BLOCKS(BLOCKS), .BLK_W(BLK_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_blk(req_blk), .rd_st(tb_st), .rd_sh(tb_sh),
    .wr_en(commit), .wr_blk(blk_q), .wr_st(nst_q), .wr_sh(nsh_q)
  );

  hdir_store #(.BLOCKS(BLOCKS), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_blk(req_blk), .rd_data(st_rd),
    .wr_en(commit && wrmem_q), .wr_blk(blk_q),
    .wr_data(fetch_q ? data_q : wbdata_q)
  );

  hdir_decide #(.NODES(NODES), .NODE_W(NODE_W), .CNT_W(CNT_W)) u_decide (
    .st(tb_st), .sh(tb_sh), .rq_type(req_type), .rq_node(req_node),
    .iv_mask(d_mask), .iv_kind(d_kind), .pend(d_pend),
    .new_st(d_nst), .new_sh(d_nsh),
    .wr_mem(d_wrmem), .use_fetch(d_fetch), .do_reply(d_reply)
  );

  hdir_pick #(.NODES(NODES), .NODE_W(NODE_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .mask(mask_q), .any(pick_any), .idx(pick_idx)
  );

  assign req_ready = (eng_q == E_IDLE);
  assign accept    = req_valid && req_ready;

  assign ivn_valid = (eng_q == E_WAIT) && pick_any;
  assign ivn_type  = kind_q;
  assign ivn_node  = pick_idx;
  assign ivn_blk   = blk_q;
  assign ivn_fire  = ivn_valid && ivn_ready;

  assign rsp_ready = (eng_q == E_WAIT) && (pend_q != '0);
  assign rsp_fire  = rsp_valid && rsp_ready;

  assign commit    = (eng_q == E_WAIT) && (mask_q == '0) && (pend_q == '0);

  assign rep_valid = (eng_q == E_REPLY);
  assign rep_node  = node_q;
  assign rep_blk   = blk_q;
  assign rep_data  = data_q;
  assign rep_fire  = rep_valid && rep_ready;

  always_comb begin
    clr_bit           = '0;
    clr_bit[pick_idx] = ivn_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_q    <= E_IDLE;
      node_q   <= '0;
      blk_q    <= '0;
      wbdata_q <= '0;
      data_q   <= '0;
      mask_q   <= '0;
      kind_q   <= IV_INV;
      pend_q   <= '0;
      nst_q    <= DS_UNC;
      nsh_q    <= '0;
      wrmem_q  <= 1'b0;
      fetch_q  <= 1'b0;
      reply_q  <= 1'b0;
      fnode_q  <= '0;
    end else begin
      case (eng_q)
        E_IDLE: begin
          if (accept) begin
            eng_q    <= E_WAIT;
            node_q   <= req_node;
            blk_q    <= req_blk;
            wbdata_q <= req_data;
            data_q   <= st_rd;
            mask_q   <= d_mask;
            kind_q   <= d_kind;
            pend_q   <= d_pend;
            nst_q    <= d_nst;
            nsh_q    <= d_nsh;
            wrmem_q  <= d_wrmem;
            fetch_q  <= d_fetch;
            reply_q  <= d_reply;
          end
        end
        E_WAIT: begin
          mask_q <= mask_q & ~clr_bit;
          if (ivn_fire && kind_q != IV_INV) fnode_q <= pick_idx;
          if (rsp_fire) begin
            pend_q <= pend_q - CNT_W'(1);
            if (rsp_type == RS_DATA && fetch_q && rsp_node == fnode_q)
              data_q <= rsp_data;
          end
          if (commit) eng_q <= reply_q ? E_REPLY : E_IDLE;
        end
        E_REPLY: begin
          if (rep_fire) eng_q <= E_IDLE;
        end
        default: eng_q <= E_IDLE;
      endcase
    end
  end

  // R8: an accepted request closes the request channel
  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R8: ready returns right after the reply is taken
  a_r8_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    rep_fire |=> req_ready);
  // R9: interventions of one request climb in node id
  a_r9_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    ivn_fire |=> !ivn_valid || (ivn_node > $past(ivn_node)));
  // R9: the requester is never a target
  a_r9_not_self: assert property (@(posedge clk) disable iff (!rst_n)
    ivn_valid |-> ivn_node != node_q);
  // R4: reply only after all interventions and responses are done
  a_r4_acks_first: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> (pend_q == '0) && (mask_q == '0));
  // R10: a stalled reply holds its contents
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid && !rep_ready |=> rep_valid && $stable(rep_data) && $stable(rep_node) && $stable(rep_blk));
endmodule

// File: tb/home_dir_ctrl_tb.sv
module home_dir_ctrl_tb;
  timeunit 1ns; timeprecision 1ps;

  localparam int NODES = 4, BLOCKS = 16, DATA_W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ready; logic [1:0] req_type = 0; logic [1:0] req_node = 0;
  logic [3:0] req_blk = 0; logic [31:0] req_data = 0;
  logic ivn_valid, ivn_ready = 1; logic [1:0] ivn_type; logic [1:0] ivn_node; logic [3:0] ivn_blk;
  logic rsp_valid = 0, rsp_ready, rsp_type = 0; logic [1:0] rsp_node = 0; logic [31:0] rsp_data = 0;
  logic rep_valid, rep_ready = 0; logic [1:0] rep_node; logic [3:0] rep_blk; logic [31:0] rep_data;

  always #5 clk = ~clk;  // 100 MHz

  home_dir_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_dut (.*);

  int checks = 0, errors = 0;
  // model: 0 uncached, 1 shared, 2 exclusive
  int         m_st  [BLOCKS];
  logic [3:0] m_sh  [BLOCKS];
  logic [31:0] m_mem[BLOCKS];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int lowest(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic run_txn(input int typ, input int node, input int blk,
                         input logic [31:0] wd, input int mode);
    logic [3:0] own, others;
    int exp_kind, exp_n, iv_seen, cyc, qh, qt;
    int exp_nodes [4];
    bit exp_rep, got_rep, acc, done, hold, rep_prev;
    logic [31:0] exp_data, fdata, hold_data;
    int q_type [8]; int q_node [8];
    string tag;
    own = 4'b1 << node; others = m_sh[blk] & ~own; fdata = $urandom;
    exp_n = 0; exp_rep = 0; exp_kind = 0; exp_data = 0; tag = "R2";
    case (typ)
      0: begin
        exp_rep = 1;
        if (m_st[blk] == 2 && others != 0) begin
          tag = "R5"; exp_kind = 1; exp_nodes[0] = lowest(others); exp_n = 1;
          exp_data = fdata; m_mem[blk] = fdata;
        end else begin tag = "R2"; exp_data = m_mem[blk]; end
        m_st[blk] = 1; m_sh[blk] = m_sh[blk] | own;
      end
      1: begin
        exp_rep = 1;
        if (m_st[blk] == 2 && others != 0) begin
          tag = "R6"; exp_kind = 2; exp_nodes[0] = lowest(others); exp_n = 1; exp_data = fdata;
        end else if (m_st[blk] == 1) begin
          tag = "R4"; exp_kind = 0; exp_data = m_mem[blk];
          for (int i = 0; i < 4; i++) if (others[i]) begin exp_nodes[exp_n] = i; exp_n++; end
        end else begin tag = "R3"; exp_data = m_mem[blk]; end
        m_st[blk] = 2; m_sh[blk] = own;
      end
      default: begin
        tag = "R7";
        if (m_st[blk] == 2 && m_sh[blk] == own) begin
          m_mem[blk] = wd; m_st[blk] = 0; m_sh[blk] = 0;
        end
      end
    endcase
    // offer the request
    req_valid = 1; req_type = 2'(typ); req_node = 2'(node); req_blk = 4'(blk); req_data = wd;
    cyc = 0;
    do begin
      #1 acc = req_ready;
      @(posedge clk); #1; cyc++;
    end while (!acc && cyc < 50);
    req_valid = 0;
    qh = 0; qt = 0; iv_seen = 0; got_rep = 0; done = 0; hold = 0; rep_prev = 0; cyc = 0;
    while (!done && cyc < 300) begin
      if (qh < qt && (mode == 1 || $urandom % 3 != 0)) begin
        rsp_valid = 1; rsp_type = q_type[qh][0]; rsp_node = 2'(q_node[qh]); rsp_data = fdata;
      end else rsp_valid = 0;
      rep_ready = (mode == 1) ? 1'b1 : ($urandom % 4 != 0);
      ivn_ready = (mode == 1) ? 1'b1 : ($urandom % 4 != 0);
      #1;
      if (hold) chk(rep_valid && rep_data == hold_data, "R10", "stalled reply changed",
                    {31'd0, rep_valid, rep_data}, {32'd1, hold_data});
      hold = 0;
      if (req_ready) begin
        done = 1;
        chk(got_rep == exp_rep, "R8", "ready before reply taken", got_rep, exp_rep);
        chk(iv_seen == exp_n, tag, "intervention count", iv_seen, exp_n);
      end else begin
        if (rep_prev) chk(0, "R8", "not ready after reply", 0, 1);
        if (ivn_valid && ivn_ready) begin
          if (iv_seen < exp_n) begin
            chk(ivn_node == exp_nodes[iv_seen] && ivn_blk == 4'(blk), "R9", "intervention target",
                {ivn_blk, ivn_node}, {4'(blk), 2'(exp_nodes[iv_seen])});
            chk(ivn_type == 2'(exp_kind), tag, "intervention type", ivn_type, exp_kind);
          end else chk(0, tag, "extra intervention", iv_seen + 1, exp_n);
          q_type[qt] = (ivn_type == 0) ? 0 : 1; q_node[qt] = ivn_node; qt++; iv_seen++;
        end
        if (rsp_valid && rsp_ready) qh++;
        if (rep_valid) begin
          if (qh < qt || iv_seen < exp_n) chk(0, "R4", "reply before acknowledgments", qt - qh, 0);
          if (rep_ready) begin
            chk(exp_rep && rep_node == 2'(node) && rep_blk == 4'(blk), tag, "reply address",
                {rep_blk, rep_node}, {4'(blk), 2'(node)});
            chk(rep_data == exp_data, tag, "reply data", rep_data, exp_data);
            got_rep = 1; rep_prev = 1;
          end else begin hold = 1; hold_data = rep_data; end
        end
      end
      @(posedge clk); #1; cyc++;
    end
    if (!done) chk(0, tag, "transaction did not finish", cyc, 0);
    rsp_valid = 0; rep_ready = 0; ivn_ready = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0dc1));
    for (int b = 0; b < BLOCKS; b++) begin m_st[b] = 0; m_sh[b] = 0; m_mem[b] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1 reset state
    chk(req_ready == 1, "R1", "ready after reset", req_ready, 1);
    chk(ivn_valid == 0 && rep_valid == 0 && rsp_ready == 0, "R1", "idle outputs",
        {ivn_valid, rep_valid, rsp_ready}, 0);
    @(posedge clk); #1;
    run_txn(0, 0, 0, 0, 0);                      // R1/R2 zero data
    for (int n = 1; n < 4; n++) run_txn(0, n, 1, 0, 0);
    run_txn(1, 0, 1, 0, 1);                      // R4 acks overlap issue
    run_txn(0, 2, 1, 0, 0);                      // R5 fetch from owner 0
    run_txn(1, 3, 1, 0, 1);                      // R4 invalidate 0 and 2
    run_txn(1, 1, 1, 0, 0);                      // R6 fetch-invalidate owner 3
    run_txn(2, 0, 1, 32'hdead_0001, 0);          // R7 non-owner ignored
    run_txn(0, 2, 1, 0, 0);                      // R7 check: fetch still goes to owner 1
    run_txn(1, 1, 1, 0, 0);
    run_txn(2, 1, 1, 32'hcafe_0002, 0);          // R7 owner write-back
    run_txn(0, 3, 1, 0, 0);                      // stored write-back data returned
    run_txn(0, 2, 4, 0, 0);
    run_txn(1, 2, 4, 0, 0);                      // R4 requester excluded: no invalidate
    for (int t = 0; t < 400; t++) begin
      int typ, node, blk;
      typ = $urandom % 3; node = $urandom % 4; blk = $urandom % 6;
      if (typ == 2 && m_st[blk] == 2 && $urandom % 10 < 7) node = lowest(m_sh[blk]);
      run_txn(typ, node, blk, $urandom, ($urandom % 4 == 0) ? 1 : 0);
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule